// File: doc/BRIEF.md
# DMA Width-Adapting Transfer Engine

This block is one DMA channel that copies a run of data from a source region to a destination region. The source and destination access widths are set separately to 1, 2 or 4 bytes. When the destination is wider than the source, the engine gathers several narrow reads into a 32-bit staging register. It then issues one wide write. When the source is wider, it splits each wide read into several narrow writes. Bytes are handled little-endian: the first byte read lands in the lowest byte lane.

Software supplies a control word, a source start address and a destination start address, and then pulses `start_i`. The control word holds the element count, counted in source-width elements, plus the two width codes and the two address-increment enables. The engine works in units. One unit moves max(source width, destination width) bytes: first all the reads of the unit, then all its writes. After the last write of a unit, the remaining count drops by the number of source reads in that unit. A count that cannot fill whole destination beats is refused. So is a reserved width code. The memory side is a single sized request/ready port.

Top module: `dma_width_engine`

## Requirements
- R1: After reset, `busy_o`, `done_o`, `err_o` and `mem_req_o` are all low.
- R2: Control word layout: bits [11:0] hold the element count in source-width units, [13:12] the source width code, [15:14] the destination width code, bit 16 the source increment enable and bit 17 the destination increment enable. Width code 0/1/2 means 1/2/4 bytes. On an accepted start, `remaining_o` shows the count in the following cycle.
- R3: With a destination wider than the source, the reads of one unit are packed little-endian into a single write. For example, a 1-byte source, a 4-byte destination and a count of 4, reading bytes 0x11, 0x22, 0x33, 0x44, write the word 0x44332211 with size code 2.
- R4: With a source wider than the destination, each read is split into writes taken from the lowest lanes first. Write data sits in the low lanes of `mem_wdata_o`, and unused upper lanes are zero. Read data is taken from the low lanes of `mem_rdata_i`.
- R5: Each read uses the current source address and the source size code. With source increment set, that address advances by the source width after every accepted read; otherwise it stays fixed.
- R6: Each write uses the current destination address with no offset and the destination size code. With destination increment set, that address advances by the destination width after every accepted write; otherwise it stays fixed.
- R7: After the last write of each unit, the remaining count drops by (unit bytes / source width). When it reaches zero, `done_o` pulses for exactly one cycle, `busy_o` falls and `remaining_o` reads 0.
- R8: If count × source width is not a multiple of the destination width, a start gives a one-cycle `err_o` pulse in the next cycle, with no memory request, and the engine stays idle.
- R9: A width code of 3 in either field gives a one-cycle `err_o` pulse in the next cycle, with no memory request.
- R10: A count of zero gives a one-cycle `done_o` pulse in the next cycle, with no memory request.
- R11: While `mem_req_o` is high and `mem_ready_i` is low, address, direction, size and write data hold steady.
- R12: A start pulse while the engine is busy is ignored. The running transfer continues unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Start pulse, sampled when idle |
| ctrl_i | input | 18 | Control word (count, width codes, increment enables) |
| src_base_i | input | 32 | Source start address |
| dst_base_i | input | 32 | Destination start address |
| mem_req_o | output | 1 | Memory request valid |
| mem_we_o | output | 1 | 1 = write, 0 = read |
| mem_size_o | output | 2 | Access size code (0/1/2 = 1/2/4 bytes) |
| mem_addr_o | output | 32 | Access byte address |
| mem_wdata_o | output | 32 | Write data, low lanes |
| mem_ready_i | input | 1 | Request accepted this cycle |
| mem_rdata_i | input | 32 | Read data, low lanes, valid with ready |
| busy_o | output | 1 | Transfer in progress |
| done_o | output | 1 | One-cycle completion pulse |
| err_o | output | 1 | One-cycle refusal pulse |
| remaining_o | output | 12 | Remaining element count |

## Verification
The checker module tests the following on every cycle:
- the request stays stable while it is stalled;
- the remaining count never grows during a transfer, and it is frozen between handshakes even when a stray start arrives;
- a refusal or completion pulse never appears while the engine is busy or requesting;
- a reserved size code never reaches the port;
- a byte-sized write carries zeros in its upper lanes.

Other behaviours can only be shown by the bench scenarios, which a scoreboard compares against a model derived from the requirements. These are the exact byte packing and splitting order, the address stepping with each increment enable on or off, the count step per unit, and the absence of any memory traffic on refused or empty transfers.

// File: rtl/dwe_pkg.sv
package dwe_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_RD   = 2'd1,
    ST_WR   = 2'd2
  } dwe_state_e;

  localparam int unsigned BUS_BYTES = 4;
  localparam int unsigned BUS_W     = BUS_BYTES * 8;
endpackage

// File: rtl/dwe_cfg_check.sv
module dwe_cfg_check #(
  parameter int CNT_W = 12
) (
  input  logic [CNT_W-1:0] count_i,
  input  logic [1:0]       src_code_i,
  input  logic [1:0]       dst_code_i,
  output logic             bad_code_o,
  output logic             mismatch_o,
  output logic [1:0]       rd_last_o,
  output logic [1:0]       wr_last_o,
  output logic [2:0]       step_o
);
  logic [1:0] unit_log;
  logic [1:0] rd_span;
  logic [1:0] wr_span;
  logic [1:0] ratio_mask;

  always_comb begin
    bad_code_o = (src_code_i == 2'd3) || (dst_code_i == 2'd3);
    unit_log   = (dst_code_i > src_code_i) ? dst_code_i : src_code_i;
    rd_span    = unit_log - src_code_i;
    wr_span    = unit_log - dst_code_i;
    rd_last_o  = 2'((3'd1 << rd_span) - 3'd1);
    wr_last_o  = 2'((3'd1 << wr_span) - 3'd1);
    step_o     = 3'd1 << rd_span;
    // reads per destination beat minus one, as a low-bit mask on the count
    ratio_mask = (dst_code_i > src_code_i)
               ? 2'((3'd1 << (dst_code_i - src_code_i)) - 3'd1) : 2'd0;
    mismatch_o = |(count_i[1:0] & ratio_mask);
  end
endmodule

// File: rtl/dwe_addr_step.sv
module dwe_addr_step #(
  parameter int ADDR_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load_i,
  input  logic [ADDR_W-1:0] base_i,
  input  logic              adv_i,
  input  logic              inc_en_i,
  input  logic [1:0]        size_log_i,
  output logic [ADDR_W-1:0] addr_o
);
  logic [ADDR_W-1:0] addr_q, addr_d;
  logic              addr_en;

  always_comb begin
    addr_en = load_i || (adv_i && inc_en_i);
    addr_d  = addr_q;
    if (load_i)
      addr_d = base_i;
    else if (adv_i && inc_en_i)
      addr_d = addr_q + ADDR_W'(3'd1 << size_log_i);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      addr_q <= '0;
    else if (addr_en)
      addr_q <= addr_d;
  end

  assign addr_o = addr_q;
endmodule

// File: rtl/dwe_pack_stage.sv
module dwe_pack_stage
  import dwe_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cap_en_i,
  input  logic [BUS_W-1:0] rdata_i,
  input  logic [1:0]       rd_beat_i,
  input  logic [1:0]       src_log_i,
  input  logic [1:0]       wr_beat_i,
  input  logic [1:0]       dst_log_i,
  output logic [BUS_W-1:0] wdata_o
);
  logic [BUS_W-1:0] stage_q, stage_d;
  logic [BUS_W-1:0] rd_shift, wr_shift;
  logic [1:0]       rd_off, wr_off;
  logic [2:0]       src_bytes, dst_bytes;

  always_comb begin
    rd_off    = 2'(rd_beat_i << src_log_i);
    src_bytes = 3'd1 << src_log_i;
    rd_shift  = rdata_i << {rd_off, 3'b000};
    stage_d   = stage_q;
    for (int i = 0; i < int'(BUS_BYTES); i++) begin
      if ((3'(i) >= {1'b0, rd_off}) && (3'(i) < ({1'b0, rd_off} + src_bytes)))
        stage_d[8*i +: 8] = rd_shift[8*i +: 8];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      stage_q <= '0;
    else if (cap_en_i)
      stage_q <= stage_d;
  end

  always_comb begin
    wr_off    = 2'(wr_beat_i << dst_log_i);
    dst_bytes = 3'd1 << dst_log_i;
    wr_shift  = stage_q >> {wr_off, 3'b000};
    for (int i = 0; i < int'(BUS_BYTES); i++)
      wdata_o[8*i +: 8] = (3'(i) < dst_bytes) ? wr_shift[8*i +: 8] : 8'h00;
  end
endmodule

// File: rtl/dma_width_engine.sv
module dma_width_engine
  import dwe_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int CNT_W  = 12,
  localparam int CTRL_W = CNT_W + 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  input  logic [CTRL_W-1:0] ctrl_i,
  input  logic [ADDR_W-1:0] src_base_i,
  input  logic [ADDR_W-1:0] dst_base_i,
  output logic              mem_req_o,
  output logic              mem_we_o,
  output logic [1:0]        mem_size_o,
  output logic [ADDR_W-1:0] mem_addr_o,
  output logic [BUS_W-1:0]  mem_wdata_o,
  input  logic              mem_ready_i,
  input  logic [BUS_W-1:0]  mem_rdata_i,
  output logic              busy_o,
  output logic              done_o,
  output logic              err_o,
  output logic [CNT_W-1:0]  remaining_o
);
  localparam int SC_LSB = CNT_W;
  localparam int DC_LSB = CNT_W + 2;
  localparam int SI_BIT = CNT_W + 4;
  localparam int DI_BIT = CNT_W + 5;

  logic [CNT_W-1:0] cnt_in;
  logic [1:0]       sc_in, dc_in;
  logic             bad_code, mismatch;
  logic [1:0]       rd_last_in, wr_last_in;
  logic [2:0]       step_in;

  dwe_state_e       state_q, state_d;
  logic [1:0]       beat_q, beat_d;
  logic [CNT_W-1:0] rem_q, rem_d, rem_left;
  logic             done_q, done_d, err_q, err_d;
  logic [1:0]       sl_q, dl_q, rd_last_q, wr_last_q;
  logic             si_q, di_q;
  logic [2:0]       step_q;
  logic             go, cap_en, src_adv, dst_adv;
  logic [ADDR_W-1:0] src_addr, dst_addr;
  logic [BUS_W-1:0]  pack_wdata;

  assign cnt_in = ctrl_i[CNT_W-1:0];
  assign sc_in  = ctrl_i[SC_LSB +: 2];
  assign dc_in  = ctrl_i[DC_LSB +: 2];

  dwe_cfg_check #(.CNT_W(CNT_W)) cfg_i (
    .count_i(cnt_in), .src_code_i(sc_in), .dst_code_i(dc_in),
    .bad_code_o(bad_code), .mismatch_o(mismatch),
    .rd_last_o(rd_last_in), .wr_last_o(wr_last_in), .step_o(step_in)
  );

  dwe_addr_step #(.ADDR_W(ADDR_W)) src_step_i (
    .clk(clk), .rst_n(rst_n), .load_i(go), .base_i(src_base_i),
    .adv_i(src_adv), .inc_en_i(si_q), .size_log_i(sl_q), .addr_o(src_addr)
  );

  dwe_addr_step #(.ADDR_W(ADDR_W)) dst_step_i (
    .clk(clk), .rst_n(rst_n), .load_i(go), .base_i(dst_base_i),
    .adv_i(dst_adv), .inc_en_i(di_q), .size_log_i(dl_q), .addr_o(dst_addr)
  );

  dwe_pack_stage pack_i (
    .clk(clk), .rst_n(rst_n), .cap_en_i(cap_en), .rdata_i(mem_rdata_i),
    .rd_beat_i(beat_q), .src_log_i(sl_q), .wr_beat_i(beat_q),
    .dst_log_i(dl_q), .wdata_o(pack_wdata)
  );

  assign rem_left = rem_q - CNT_W'(step_q);

  always_comb begin
    state_d = state_q;
    beat_d  = beat_q;
    rem_d   = rem_q;
    done_d  = 1'b0;
    err_d   = 1'b0;
    go      = 1'b0;
    cap_en  = 1'b0;
    src_adv = 1'b0;
    dst_adv = 1'b0;
    unique case (state_q)
      ST_IDLE: begin
        if (start_i) begin
          if (bad_code || mismatch) begin
            err_d = 1'b1;
          end else if (cnt_in == '0) begin
            done_d = 1'b1;
          end else begin
            go      = 1'b1;
            state_d = ST_RD;
            rem_d   = cnt_in;
            beat_d  = 2'd0;
          end
        end
      end
      ST_RD: begin
        if (mem_ready_i) begin
          cap_en  = 1'b1;
          src_adv = 1'b1;
          if (beat_q == rd_last_q) begin
            beat_d  = 2'd0;
            state_d = ST_WR;
          end else begin
            beat_d = beat_q + 2'd1;
          end
        end
      end
      ST_WR: begin
        if (mem_ready_i) begin
          dst_adv = 1'b1;
          if (beat_q == wr_last_q) begin
            beat_d = 2'd0;
            rem_d  = rem_left;
            if (rem_left == '0) begin
              done_d  = 1'b1;
              state_d = ST_IDLE;
            end else begin
              state_d = ST_RD;
            end
          end else begin
            beat_d = beat_q + 2'd1;
          end
        end
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      beat_q  <= 2'd0;
      rem_q   <= '0;
      done_q  <= 1'b0;
      err_q   <= 1'b0;
    end else begin
      state_q <= state_d;
      beat_q  <= beat_d;
      rem_q   <= rem_d;
      done_q  <= done_d;
      err_q   <= err_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sl_q      <= 2'd0;
      dl_q      <= 2'd0;
      si_q      <= 1'b0;
      di_q      <= 1'b0;
      rd_last_q <= 2'd0;
      wr_last_q <= 2'd0;
      step_q    <= 3'd1;
    end else if (go) begin
      sl_q      <= sc_in;
      dl_q      <= dc_in;
      si_q      <= ctrl_i[SI_BIT];
      di_q      <= ctrl_i[DI_BIT];
      rd_last_q <= rd_last_in;
      wr_last_q <= wr_last_in;
      step_q    <= step_in;
    end
  end

  assign busy_o      = (state_q != ST_IDLE);
  assign mem_req_o   = (state_q == ST_RD) || (state_q == ST_WR);
  assign mem_we_o    = (state_q == ST_WR);
  assign mem_size_o  = (state_q == ST_WR) ? dl_q : sl_q;
  assign mem_addr_o  = (state_q == ST_WR) ? dst_addr : src_addr;
  assign mem_wdata_o = (state_q == ST_WR) ? pack_wdata : '0;
  assign done_o      = done_q;
  assign err_o       = err_q;
  assign remaining_o = rem_q;
endmodule

// File: rtl/dwe_checker.sv
module dwe_checker #(
  parameter int ADDR_W = 32,
  parameter int CNT_W  = 12
) (
  input logic              clk,
  input logic              rst_n,
  input logic              busy,
  input logic              done,
  input logic              err,
  input logic              mem_req,
  input logic              mem_ready,
  input logic              mem_we,
  input logic [1:0]        mem_size,
  input logic [ADDR_W-1:0] mem_addr,
  input logic [31:0]       mem_wdata,
  input logic [CNT_W-1:0]  remaining
);
  AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && !mem_ready |=> mem_req && $stable(mem_addr) && $stable(mem_we) && $stable(mem_size) && $stable(mem_wdata)); // R11

  AST_REM_NO_GROW: assert property (@(posedge clk) disable iff (!rst_n)
    busy && $past(busy) |-> remaining <= $past(remaining)); // R7

  AST_REM_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
    busy && !(mem_req && mem_ready) |=> $stable(remaining)); // R12

  AST_ERR_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    err |-> !busy && !mem_req && !done); // R8

  AST_DONE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy && !mem_req); // R10

  AST_SIZE_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req |-> mem_size != 2'd3); // R9

  AST_BYTE_UPPER_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && mem_we && mem_size == 2'd0 |-> mem_wdata[31:8] == 24'd0); // R4
endmodule

bind dma_width_engine dwe_checker #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) chk_i (
  .clk(clk), .rst_n(rst_n), .busy(busy_o), .done(done_o), .err(err_o),
  .mem_req(mem_req_o), .mem_ready(mem_ready_i), .mem_we(mem_we_o),
  .mem_size(mem_size_o), .mem_addr(mem_addr_o), .mem_wdata(mem_wdata_o),
  .remaining(remaining_o)
);

// File: tb/dma_width_engine_tb_top.sv
`timescale 1ns/1ps
module dma_width_engine_tb_top;
  typedef struct {
    logic        we;
    logic [31:0] addr;
    logic [1:0]  size;
    logic [31:0] data;
  } txn_t;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        start_i;
  logic [17:0] ctrl_i;
  logic [31:0] src_base_i, dst_base_i;
  logic        mem_req_o, mem_we_o, mem_ready_i;
  logic [1:0]  mem_size_o;
  logic [31:0] mem_addr_o, mem_wdata_o, mem_rdata_i;
  logic        busy_o, done_o, err_o;
  logic [11:0] remaining_o;

  logic [7:0]  mem [0:255];
  txn_t        exp_q[$];
  string       cur_tag;
  int          checks = 0;
  int          failures = 0;
  int          cyc = 0;
  bit          stall_en = 0;
  bit          hold_pend = 0;
  logic [31:0] hold_addr;
  logic        hold_we;

  always #2.5 clk = ~clk;

  dma_width_engine dut_i (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .ctrl_i(ctrl_i),
    .src_base_i(src_base_i), .dst_base_i(dst_base_i),
    .mem_req_o(mem_req_o), .mem_we_o(mem_we_o), .mem_size_o(mem_size_o),
    .mem_addr_o(mem_addr_o), .mem_wdata_o(mem_wdata_o),
    .mem_ready_i(mem_ready_i), .mem_rdata_i(mem_rdata_i),
    .busy_o(busy_o), .done_o(done_o), .err_o(err_o), .remaining_o(remaining_o)
  );

  always_comb begin
    mem_rdata_i = {mem[8'(mem_addr_o[7:0] + 8'd3)], mem[8'(mem_addr_o[7:0] + 8'd2)],
                   mem[8'(mem_addr_o[7:0] + 8'd1)], mem[mem_addr_o[7:0]]};
    if (mem_size_o == 2'd0) mem_rdata_i[31:8] = '0;
    else if (mem_size_o == 2'd1) mem_rdata_i[31:16] = '0;
  end

  task automatic check(bit ok, string req, string what, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  // memory responder and scoreboard monitor
  initial begin
    mem_ready_i = 1'b1;
    forever begin
      @(negedge clk);
      cyc++;
      mem_ready_i = stall_en ? ((cyc % 3) != 1) : 1'b1;
      #1;
      if (hold_pend) begin
        check(mem_addr_o == hold_addr && mem_we_o == hold_we && mem_req_o,
              "R11", "stalled request changed", mem_addr_o, hold_addr);
      end
      hold_pend = mem_req_o && !mem_ready_i;
      hold_addr = mem_addr_o;
      hold_we   = mem_we_o;
      if (mem_req_o && mem_ready_i) begin
        if (exp_q.size() == 0) begin
          check(1'b0, cur_tag, "unexpected memory access", mem_addr_o, 32'h0);
        end else begin
          txn_t e;
          e = exp_q.pop_front();
          check(mem_we_o == e.we && mem_addr_o == e.addr && mem_size_o == e.size,
                cur_tag, "access we/addr/size", {mem_we_o, mem_size_o, mem_addr_o[28:0]},
                {e.we, e.size, e.addr[28:0]});
          if (e.we)
            check(mem_wdata_o == e.data, cur_tag, "write data", mem_wdata_o, e.data);
        end
        if (mem_we_o) begin
          for (int b = 0; b < (1 << mem_size_o); b++)
            mem[8'(mem_addr_o[7:0] + 8'(b))] = mem_wdata_o[8*b +: 8];
        end
      end
    end
  end

  task automatic run_xfer(string tag, int cnt, int sc, int dc, bit si, bit di,
                          int src, int dst, bit stall, int mid_start);
    bit bad, mism, good;
    int sw, dw, unit, rem, s, d;
    logic [7:0] stg [0:3];
    bad  = (sc > 2) || (dc > 2);
    sw   = 1 << sc;
    dw   = 1 << dc;
    mism = !bad && (((cnt * sw) % dw) != 0);
    good = !bad && !mism && (cnt > 0);
    if (good) begin
      unit = (sw > dw) ? sw : dw;
      rem = cnt; s = src; d = dst;
      while (rem > 0) begin
        for (int k = 0; k < unit / sw; k++) begin
          txn_t t;
          t.we = 1'b0; t.addr = 32'(s); t.size = 2'(sc); t.data = '0;
          exp_q.push_back(t);
          for (int b = 0; b < sw; b++) stg[k*sw + b] = mem[8'(s + b)];
          if (si) s += sw;
        end
        for (int k = 0; k < unit / dw; k++) begin
          txn_t t;
          t.we = 1'b1; t.addr = 32'(d); t.size = 2'(dc); t.data = '0;
          for (int b = 0; b < dw; b++) t.data[8*b +: 8] = stg[k*dw + b];
          exp_q.push_back(t);
          if (di) d += dw;
        end
        rem -= unit / sw;
      end
    end
    cur_tag = tag;
    @(negedge clk);
    #2;
    stall_en   = stall;
    ctrl_i     = {di, si, 2'(dc), 2'(sc), 12'(cnt)};
    src_base_i = 32'(src);
    dst_base_i = 32'(dst);
    start_i    = 1'b1;
    @(negedge clk);
    #2;
    start_i = 1'b0;
    if (bad || mism) begin
      check(err_o && !busy_o && !done_o, bad ? "R9" : "R8", "refusal pulse", {err_o, busy_o, done_o}, 3'b100);
    end else if (cnt == 0) begin
      check(done_o && !busy_o && !err_o, "R10", "zero-count done", {done_o, busy_o, err_o}, 3'b100);
    end else begin
      check(busy_o == 1'b1, "R2", "busy after start", busy_o, 1'b1);
      check(remaining_o == 12'(cnt), "R2", "count loaded", remaining_o, 32'(cnt));
      for (int i = 0; i < 3000; i++) begin
        if (done_o) break;
        @(negedge clk);
        #2;
        if (mid_start > 0 && i == mid_start) begin
          ctrl_i     = {1'b1, 1'b1, 2'd0, 2'd0, 12'd1};
          src_base_i = 32'h40;
          dst_base_i = 32'h50;
          start_i    = 1'b1;
        end else begin
          start_i = 1'b0;
        end
      end
      start_i = 1'b0;
      check(done_o == 1'b1, "R7", "done reached", done_o, 1'b1);
      check(remaining_o == 12'd0 && !busy_o, "R7", "count zero, idle at done", {busy_o, remaining_o}, 13'd0);
    end
    @(negedge clk);
    #2;
    check(!done_o && !err_o, "R7", "status is single-cycle pulse", {done_o, err_o}, 2'b00);
    repeat (4) @(negedge clk);
    #2;
    check(exp_q.size() == 0 && !mem_req_o, tag, "scoreboard drained", exp_q.size(), 0);
    exp_q.delete();
    stall_en = 0;
  endtask

  initial begin
    for (int i = 0; i < 256; i++) mem[i] = 8'(i * 7 + 3);
    mem[0] = 8'h11; mem[1] = 8'h22; mem[2] = 8'h33; mem[3] = 8'h44;
    rst_n = 1'b0; start_i = 1'b0; ctrl_i = '0; src_base_i = '0; dst_base_i = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    #2;
    check(!busy_o && !done_o && !err_o && !mem_req_o, "R1", "reset state",
          {busy_o, done_o, err_o, mem_req_o}, 4'b0000);

    run_xfer("R3", 4, 0, 2, 1, 1, 32'h00, 32'h80, 0, 0);
    check({mem[8'h83], mem[8'h82], mem[8'h81], mem[8'h80]} == 32'h44332211, "R3",
          "packed word", {mem[8'h83], mem[8'h82], mem[8'h81], mem[8'h80]}, 32'h44332211);
    run_xfer("R4", 2, 2, 0, 1, 1, 32'h10, 32'h90, 0, 0);
    run_xfer("R5 R6 R11", 6, 1, 2, 1, 1, 32'h20, 32'hA0, 1, 0);
    run_xfer("R5", 4, 0, 1, 0, 1, 32'h30, 32'hB0, 0, 0);
    run_xfer("R6", 3, 1, 0, 1, 0, 32'h34, 32'hC0, 1, 0);
    run_xfer("R8", 5, 0, 2, 1, 1, 32'h00, 32'h80, 0, 0);
    run_xfer("R9", 4, 3, 0, 1, 1, 32'h00, 32'h80, 0, 0);
    run_xfer("R10", 0, 0, 0, 1, 1, 32'h00, 32'h80, 0, 0);
    run_xfer("R12", 8, 0, 0, 1, 1, 32'h00, 32'hD0, 1, 3);
    run_xfer("R2 R7", 2, 2, 2, 1, 1, 32'h08, 32'hE0, 1, 0);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    failures++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule